// File: doc/BRIEF.md
# ADC Read Command Sequencer

This block handles the converter-read transaction of a two-wire serial slave whose device-type code is 4'b1001. A bit-level engine, which lies outside this block, delivers the received address bytes and data bytes and asks for outgoing read bytes. The block decides whether each byte is acknowledged. A master starts a read with a dummy write: a write address byte, then a word-address byte. The block takes the channel number from that word-address byte. It pulses a start strobe toward the converter and keeps the channel number on an output for the whole conversion.

While the conversion runs, the block refuses every address byte aimed at it. The master therefore has to poll with address bytes until one is acknowledged. When the conversion finishes, the block latches the result. The next read then returns two bytes: the 4-bit channel number with the upper result bits, then the lower eight result bits.

By default, the end of a conversion is signalled by the converter's done pulse. A parameter can select an internal cycle counter instead. That counter stands in for the fixed conversion time, which is 70 µs, or 8750 cycles at 125 MHz.

Top module: `adcrd_seq`

## Requirements
- R1: An address byte is taken to target this slave only when bits [7:4] equal 4'b1001 and bits [3:1] equal the bus address (3'b000 by default). Bit 0 is the direction: 0 means write and 1 means read. In idle, a write address byte that targets this slave is acknowledged. Any byte that does not target this slave is never acknowledged.
- R2: The channel number is bits [6:3] of the word-address byte. It appears on `conv_chan` and stays constant while `busy` is high.
- R3: The clock edge that accepts the word-address byte starts the conversion. From that edge, `conv_start` is high for exactly one cycle and `busy` is high.
- R4: While `busy` is high, every address byte that targets this slave is answered with NACK, whether it is a write or a read. This includes an address byte that arrives in the same cycle as the done pulse.
- R5: In done-pin mode, a `conv_done` pulse during the conversion ends it, and `busy` is low from the next cycle.
- R6: After completion, a read address byte is acknowledged. The first read byte is {channel[3:0], 2'b00, result[9:8]}, and the second is result[7:0].
- R7: The result is latched on the done pulse. Later changes on `conv_data` have no effect, and a new read after a full read and STOP returns the same two bytes.
- R8: A write address byte after a completed conversion is acknowledged. The dummy write that follows starts a new conversion on the newly selected channel.
- R9: A STOP after a read that returned fewer than two bytes discards the result. From then on, a read address byte is answered with NACK.
- R10: When no result is held (after reset, or after a discard), a read address byte is answered with NACK.
- R11: A read byte requested after the second one returns 8'hFF.
- R12: A `conv_done` pulse outside a conversion is ignored: `busy` stays low, and a read address byte is still answered with NACK.
- R13: A data byte is acknowledged only as the word-address byte that directly follows an acknowledged write address byte. At any other time it gets NACK and starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | An address byte is presented this cycle |
| addr_byte | input | 8 | Address byte: type code, bus address, direction bit |
| addr_ack | output | 1 | Acknowledge for the presented address byte (same cycle) |
| data_valid | input | 1 | A written data byte is presented this cycle |
| data_byte | input | 8 | Written data byte |
| data_ack | output | 1 | Acknowledge for the presented data byte (same cycle) |
| rd_req | input | 1 | The current read byte was shifted out; advance to the next |
| rd_data | output | 8 | Read byte to shift out |
| stop_det | input | 1 | STOP condition seen on the bus |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_chan | output | 4 | Channel being converted |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | RES_W | Converter result, valid with the done pulse |
| busy | output | 1 | Conversion in progress |

## Verification
The interesting collision is a polling address byte that arrives in the very cycle the converter's done pulse arrives. The bench disables its converter model and drives both inputs on the same clock edge. It expects NACK for that byte, because the decision is taken on the state before the edge, and expects `busy` to be low one cycle later. The next poll must then be acknowledged and must return the result delivered with that done pulse.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,   // nothing held, waiting for a dummy write
      ST_WORD = 3'd1,   // write address taken, waiting for the word address
      ST_CONV = 3'd2,   // conversion running, all addressing refused
      ST_HOLD = 3'd3,   // result latched, addressing accepted
      ST_READ = 3'd4    // read bytes being shifted out
   } adcrd_state_e;

   localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/adcrd_addr_match.sv
module adcrd_addr_match #(
   parameter logic [3:0] DEV_CODE  = 4'b1001,
   parameter logic [2:0] BUS_ADDR  = 3'b000,
   parameter bit         MATCH_BUS = 1'b1
) (
   input  logic [7:0] addr_byte,
   output logic       hit,
   output logic       is_rd
);

   logic code_ok;
   logic bus_ok;

   assign code_ok = (addr_byte[7:4] == DEV_CODE);
   assign is_rd   = addr_byte[0];

   generate
      if (MATCH_BUS) begin : g_bus_cmp
         assign bus_ok = (addr_byte[3:1] == BUS_ADDR);
      end else begin : g_bus_any
         logic unused_bus;
         assign unused_bus = ^addr_byte[3:1];
         assign bus_ok     = 1'b1;
      end
   endgenerate

   assign hit = code_ok & bus_ok;

endmodule

// File: rtl/adcrd_conv_timer.sv
module adcrd_conv_timer #(
   parameter int CONV_CYCLES = 8750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic finish
);

   localparam int CW = $clog2(CONV_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (!finish) cnt_q <= cnt_q + 1'b1;
   end

   assign finish = run && (cnt_q == LAST);

endmodule

// File: rtl/adcrd_result_reg.sv
module adcrd_result_reg
   import adcrd_pkg::*;
#(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [3:0]       load_chan,
   input  logic [RES_W-1:0] load_res,
   input  logic             rewind,
   input  logic             advance,
   output logic [7:0]       rd_data,
   output logic             both_read
);

   localparam int PAD_W = 12 - RES_W;

   logic [3:0]       chan_q;
   logic [RES_W-1:0] res_q;
   logic [1:0]       idx_q;
   logic [7:0]       hi_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_q <= '0;
         res_q  <= '0;
         idx_q  <= 2'd0;
      end else if (load) begin
         chan_q <= load_chan;
         res_q  <= load_res;
         idx_q  <= 2'd0;
      end else if (rewind) begin
         idx_q  <= 2'd0;
      end else if (advance && idx_q != 2'd2) begin
         idx_q  <= idx_q + 2'd1;
      end
   end

   assign hi_byte = {chan_q, {PAD_W{1'b0}}, res_q[RES_W-1:8]};

   always_comb begin
      case (idx_q)
         2'd0:    rd_data = hi_byte;
         2'd1:    rd_data = res_q[7:0];
         default: rd_data = FILL_BYTE;
      endcase
   end

   assign both_read = (idx_q == 2'd2);

endmodule

// File: rtl/adcrd_seq.sv
module adcrd_seq
   import adcrd_pkg::*;
#(
   parameter logic [3:0] DEV_CODE      = 4'b1001,
   parameter logic [2:0] BUS_ADDR      = 3'b000,
   parameter bit         MATCH_BUS     = 1'b1,
   parameter int         CH_LSB        = 3,
   parameter int         RES_W         = 10,
   parameter bit         DONE_FROM_PIN = 1'b1,
   parameter int         CONV_CYCLES   = 8750
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_valid,
   input  logic [7:0]       addr_byte,
   output logic             addr_ack,
   input  logic             data_valid,
   input  logic [7:0]       data_byte,
   output logic             data_ack,
   input  logic             rd_req,
   output logic [7:0]       rd_data,
   input  logic             stop_det,
   output logic             conv_start,
   output logic [3:0]       conv_chan,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_data,
   output logic             busy
);

   generate
      if (RES_W < 9 || RES_W > 11) begin : g_bad_res_w
         $error("adcrd_seq: RES_W must lie in 9..11");
      end
      if (CH_LSB < 0 || CH_LSB > 4) begin : g_bad_ch_lsb
         $error("adcrd_seq: channel field must fit in the word byte");
      end
      if (CONV_CYCLES < 1) begin : g_bad_cycles
         $error("adcrd_seq: CONV_CYCLES must be at least 1");
      end
   endgenerate

   adcrd_state_e st_q, st_d;
   logic         hit, is_rd, take_addr;
   logic         finish, load, rewind, advance, both_read;
   logic         start_q;
   logic [3:0]   chan_q;
   logic         unused_data;

   assign unused_data = ^data_byte;

   adcrd_addr_match #(
      .DEV_CODE  (DEV_CODE),
      .BUS_ADDR  (BUS_ADDR),
      .MATCH_BUS (MATCH_BUS)
   ) u_match (
      .addr_byte (addr_byte),
      .hit       (hit),
      .is_rd     (is_rd)
   );

   generate
      if (DONE_FROM_PIN) begin : g_done_pin
         assign finish = (st_q == ST_CONV) && conv_done;
      end else begin : g_done_timed
         logic unused_done;
         assign unused_done = conv_done;
         adcrd_conv_timer #(
            .CONV_CYCLES (CONV_CYCLES)
         ) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (st_q == ST_CONV),
            .finish (finish)
         );
      end
   endgenerate

   // Acknowledge decision is made on the state before the edge.
   always_comb begin
      take_addr = 1'b0;
      if (addr_valid && hit) begin
         case (st_q)
            ST_IDLE: take_addr = !is_rd;
            ST_HOLD: take_addr = 1'b1;
            default: take_addr = 1'b0;
         endcase
      end
   end

   assign addr_ack = take_addr;
   assign data_ack = data_valid && (st_q == ST_WORD);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (take_addr) st_d = ST_WORD;
         ST_WORD: begin
            if (data_valid)    st_d = ST_CONV;
            else if (stop_det) st_d = ST_IDLE;
         end
         ST_CONV: if (finish) st_d = ST_HOLD;
         ST_HOLD: if (take_addr) st_d = is_rd ? ST_READ : ST_WORD;
         ST_READ: if (stop_det) st_d = both_read ? ST_HOLD : ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   assign load    = (st_q == ST_CONV) && finish;
   assign rewind  = (st_q == ST_HOLD) && take_addr && is_rd;
   assign advance = (st_q == ST_READ) && rd_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         start_q <= 1'b0;
         chan_q  <= 4'd0;
      end else begin
         st_q    <= st_d;
         start_q <= (st_q == ST_WORD) && data_valid;
         if ((st_q == ST_WORD) && data_valid)
            chan_q <= data_byte[CH_LSB +: 4];
      end
   end

   adcrd_result_reg #(
      .RES_W (RES_W)
   ) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_chan (chan_q),
      .load_res  (conv_data),
      .rewind    (rewind),
      .advance   (advance),
      .rd_data   (rd_data),
      .both_read (both_read)
   );

   assign conv_start = start_q;
   assign conv_chan  = chan_q;
   assign busy       = (st_q == ST_CONV);

endmodule

// File: rtl/adcrd_seq_chk.sv
module adcrd_seq_chk #(
   parameter bit DONE_FROM_PIN = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       addr_valid,
   input logic       addr_ack,
   input logic       data_ack,
   input logic       conv_start,
   input logic [3:0] conv_chan,
   input logic       conv_done,
   input logic       busy
);

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start); // R3

   AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy); // R3

   AST_BUSY_RISE_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> conv_start); // R3

   AST_NACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && addr_valid) |-> !addr_ack); // R4

   AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(conv_chan)); // R2

   AST_BUSY_END_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (!DONE_FROM_PIN || $past(conv_done))); // R5

   AST_NO_DATA_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !data_ack); // R13

endmodule

bind adcrd_seq adcrd_seq_chk #(
   .DONE_FROM_PIN (DONE_FROM_PIN)
) u_adcrd_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_valid (addr_valid),
   .addr_ack   (addr_ack),
   .data_ack   (data_ack),
   .conv_start (conv_start),
   .conv_chan  (conv_chan),
   .conv_done  (conv_done),
   .busy       (busy)
);

// File: tb/tb_adcrd_seq.sv
module tb_adcrd_seq;

   localparam int CONV_CYC = 20;
   localparam int RES_W    = 10;
   localparam logic [7:0] A_WR = 8'h90;
   localparam logic [7:0] A_RD = 8'h91;
   localparam int NVEC = 6;
   // {channel, result}
   localparam logic [13:0] VEC [NVEC] = '{
      {4'd0,  10'h000}, {4'd15, 10'h3FF}, {4'd5, 10'h2A5},
      {4'd10, 10'h15A}, {4'd3,  10'h100}, {4'd12, 10'h0FF}
   };

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             addr_valid = 1'b0, data_valid = 1'b0, rd_req = 1'b0, stop_det = 1'b0;
   logic [7:0]       addr_byte = 8'h00, data_byte = 8'h00;
   logic             addr_ack, data_ack, conv_start, busy, conv_done;
   logic [7:0]       rd_data;
   logic [3:0]       conv_chan;
   logic [RES_W-1:0] conv_data;

   // converter model
   logic             emu_en = 1'b1, emu_run = 1'b0, emu_done = 1'b0, man_done = 1'b0;
   int               emu_cnt = 0;
   logic [RES_W-1:0] cur_res = '0;

   assign conv_done = emu_done | man_done;
   assign conv_data = conv_done ? cur_res : ~cur_res;

   always @(posedge clk) begin
      emu_done <= 1'b0;
      if (!rst_n) begin
         emu_run <= 1'b0;
         emu_cnt <= 0;
      end else if (conv_start && emu_en) begin
         emu_run <= 1'b1;
         emu_cnt <= 1;
      end else if (emu_run) begin
         if (emu_cnt == CONV_CYC - 1) begin
            emu_done <= 1'b1;
            emu_run  <= 1'b0;
         end else emu_cnt <= emu_cnt + 1;
      end
   end

   adcrd_seq #(.CONV_CYCLES(CONV_CYC)) dut (
      .clk(clk), .rst_n(rst_n),
      .addr_valid(addr_valid), .addr_byte(addr_byte), .addr_ack(addr_ack),
      .data_valid(data_valid), .data_byte(data_byte), .data_ack(data_ack),
      .rd_req(rd_req), .rd_data(rd_data), .stop_det(stop_det),
      .conv_start(conv_start), .conv_chan(conv_chan),
      .conv_done(conv_done), .conv_data(conv_data), .busy(busy)
   );

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send_addr(input logic [7:0] b, output logic ack);
      @(negedge clk);
      addr_valid = 1'b1; addr_byte = b;
      #1 ack = addr_ack;
      @(negedge clk);
      addr_valid = 1'b0;
   endtask

   task automatic send_data(input logic [7:0] b, output logic ack, output logic st);
      @(negedge clk);
      data_valid = 1'b1; data_byte = b;
      #1 ack = data_ack;
      @(negedge clk);
      data_valid = 1'b0;
      #1 st = conv_start;
   endtask

   task automatic read_byte(output logic [7:0] d);
      @(negedge clk);
      #1 d = rd_data;
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic send_stop();
      @(negedge clk);
      stop_det = 1'b1;
      @(negedge clk);
      stop_det = 1'b0;
   endtask

   function automatic logic [7:0] hi_of(input logic [3:0] ch, input logic [9:0] r);
      return {ch, 2'b00, r[9:8]};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic a, st;
      logic [7:0] d;
      int nacks;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk(busy == 1'b0, "reset busy", busy, 0);
      chk(conv_start == 1'b0, "reset conv_start", conv_start, 0);

      // R10: no result after reset
      send_addr(A_RD, a);
      chk(a == 1'b0, "R10 read addr after reset", a, 0);
      // R13: stray data byte in idle
      send_data(8'h28, a, st);
      chk(a == 1'b0, "R13 data ack in idle", a, 0);
      chk(st == 1'b0, "R13 no start in idle", st, 0);
      // R1: wrong type code and wrong bus address
      send_addr(8'hA0, a);
      chk(a == 1'b0, "R1 other type code", a, 0);
      send_addr(8'h92, a);
      chk(a == 1'b0, "R1 other bus address", a, 0);
      // R12: stray done in idle
      @(negedge clk) man_done = 1'b1;
      @(negedge clk) man_done = 1'b0;
      #1 chk(busy == 1'b0, "R12 busy after stray done", busy, 0);
      send_addr(A_RD, a);
      chk(a == 1'b0, "R12 read addr after stray done", a, 0);

      // table of vectors, each a full transaction
      for (int i = 0; i < NVEC; i++) begin
         logic [3:0] ch;
         logic [9:0] rs;
         ch = VEC[i][13:10];
         rs = VEC[i][9:0];
         cur_res = rs;
         send_addr(A_WR, a);
         chk(a == 1'b1, (i == 0) ? "R1 write addr" : "R8 write addr after result", a, 1);
         send_data({1'b1, ch, 3'b101}, a, st);
         chk(a == 1'b1, "R13 word byte ack", a, 1);
         chk(st == 1'b1 && busy == 1'b1, "R3 start and busy", {st, busy}, 3);
         chk(conv_chan == ch, (i == 0) ? "R2 channel" : "R8 new channel", conv_chan, ch);
         #1 @(negedge clk);
         #1 chk(conv_start == 1'b0, "R3 start one cycle", conv_start, 0);
         send_addr(A_WR, a);
         chk(a == 1'b0, "R4 write addr while busy", a, 0);
         nacks = 0;
         do begin
            send_addr(A_RD, a);
            if (!a) nacks++;
         end while (!a && nacks < 200);
         chk(a == 1'b1 && nacks > 0, "R4 poll nacked then acked", nacks, 1);
         chk(busy == 1'b0, "R5 busy low after done", busy, 0);
         read_byte(d);
         chk(d == hi_of(ch, rs), "R6 first byte", d, hi_of(ch, rs));
         read_byte(d);
         chk(d == rs[7:0], "R6 second byte", d, rs[7:0]);
         send_stop();
      end

      // same cycle: poll address byte together with the done pulse
      emu_en = 1'b0;
      send_addr(A_WR, a);
      send_data({1'b0, 4'd6, 3'b000}, a, st);
      repeat (3) @(negedge clk);
      cur_res = 10'h1C7;
      addr_valid = 1'b1; addr_byte = A_RD; man_done = 1'b1;
      #1 chk(addr_ack == 1'b0, "R4 poll in done cycle", addr_ack, 0);
      @(negedge clk);
      addr_valid = 1'b0; man_done = 1'b0;
      #1 chk(busy == 1'b0, "R5 busy low after pin done", busy, 0);
      emu_en = 1'b1;
      send_addr(A_RD, a);
      chk(a == 1'b1, "R6 read after same-cycle done", a, 1);
      read_byte(d);
      chk(d == 8'h61, "R6 first byte ch6", d, 8'h61);
      read_byte(d);
      chk(d == 8'hC7, "R6 second byte", d, 8'hC7);
      read_byte(d);
      chk(d == 8'hFF, "R11 third byte fill", d, 8'hFF);
      send_stop();
      // R7: conv_data now shows garbage; latched value must persist
      send_addr(A_RD, a);
      chk(a == 1'b1, "R7 re-read ack", a, 1);
      read_byte(d);
      chk(d == 8'h61, "R7 re-read first byte", d, 8'h61);
      // R9: partial read then STOP discards
      send_stop();
      send_addr(A_RD, a);
      chk(a == 1'b0, "R9 read after partial read", a, 0);
      send_addr(A_WR, a);
      chk(a == 1'b1, "R9 write addr acked in idle", a, 1);
      send_stop();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule